// File: doc/BRIEF.md
# DMA Address Scatter/Gather Translation Map

This block lets a peripheral DMA engine with a 22-bit (4 MB) address range reach a 24-bit (16 MB) local memory. The device address space is cut into 512-byte pages. Each page is remapped on its own through a table of map registers that host software loads. Consecutive device pages can therefore land anywhere in physical memory, which lets a device scatter writes into scattered buffers and gather reads from them.

On every accepted DMA request, the upper 13 address bits pick a map entry. The low 9 bits pass through as the byte offset, below the 15-bit page frame held in that entry. An entry whose valid flag is clear yields a fault instead of an address. The result appears one cycle after acceptance, on a valid/ready response port that can stall the request side.

The host port writes and reads entries directly by index. The table depth is a parameter, and its default implements 1024 of the 8192 possible indices. Indices beyond the implemented depth behave as permanently unmapped.

Top module: `sgmap_dma_xlate`

## Requirements
- R1: For a request address A whose entry (index A[21:9]) is valid, the response carries rsp_err = 0 and rsp_paddr = {entry page frame, A[8:0]}, with the frame in rsp_paddr[23:9].
- R2: The byte offset rsp_paddr[8:0] always equals the request's A[8:0] whenever rsp_err = 0.
- R3: A request hitting an entry whose valid flag (register bit 31) is clear returns rsp_err = 1 and rsp_paddr = 0.
- R4: With host_we = 1, the entry at host_idx takes valid = host_wdata[31] and page frame = host_wdata[14:0] at the clock edge. host_rdata shows the entry at host_idx combinationally as {valid, sixteen zero bits in 30:15, frame in 14:0}.
- R5: Reset (rst_n low at a clock edge) clears every valid flag. After reset, host_rdata[31] reads 0 and every translation faults until the entry is rewritten.
- R6: A request accepted at clock edge N (req_valid and req_ready both high) gives rsp_valid = 1 right after edge N. With no accepted request and no stalled response, rsp_valid is 0 after the edge. Right after reset, req_ready = 1 and rsp_valid = 0.
- R7: While rsp_valid = 1 and rsp_ready = 0, req_ready is 0, and rsp_paddr and rsp_err hold steady. A request waiting during the stall is accepted once the stall clears and is answered next.
- R8: When a host write and an accepted request target the same entry at the same edge, the translation uses the entry's contents from before the write.
- R9: Indices at or above MAP_ENTRIES (default 1024) are not implemented. They read back as all zeros, host writes to them change no entry (and do not alias a lower entry), and requests to them fault as in R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_we | input | 1 | Host write strobe for the entry at host_idx |
| host_idx | input | 13 | Host entry index, for both write and read |
| host_wdata | input | 32 | Host write data: bit 31 valid, bits 14:0 page frame |
| host_rdata | output | 32 | Contents of the entry at host_idx |
| req_valid | input | 1 | DMA request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_addr | input | 22 | Device-side DMA address |
| rsp_valid | output | 1 | Translation result present |
| rsp_ready | input | 1 | Consumer takes the result this cycle |
| rsp_paddr | output | 24 | Physical address, zero on a fault |
| rsp_err | output | 1 | Entry was unmapped |

## Verification
The checker watches the handshake on every cycle. It covers: each accepted request gives a response on the next cycle, and nothing appears without one. A stalled response holds its value while req_ready stays low. A fault always carries a zero address. A good result keeps the request's byte offset. The remaining behaviours depend on table contents, so only the bench's scenarios can show them: the frame placement from R1, the readback layout, reset clearing the flags, the old-contents rule on a same-cycle write, and the non-aliasing of unimplemented indices.

// File: rtl/sgmap_pkg.sv
package sgmap_pkg;
   // Map register layout shared by the host port and the table
   localparam int unsigned MAP_REG_W     = 32;
   localparam int unsigned MAP_VALID_POS = 31;

   // Outcome of one translation
   typedef enum logic {
      XL_OK    = 1'b0,
      XL_FAULT = 1'b1
   } xl_status_e;
endpackage

// File: rtl/sgmap_table.sv
module sgmap_table #(
   parameter int unsigned IDX_W   = 13,
   parameter int unsigned PFN_W   = 15,
   parameter int unsigned ENTRIES = 1024,
   parameter int unsigned NRD     = 2,
   localparam int unsigned SEL_W  = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_valid,
   input  logic [PFN_W-1:0] wr_pfn,
   input  logic [IDX_W-1:0] rd_idx   [NRD],
   output logic             rd_valid [NRD],
   output logic [PFN_W-1:0] rd_pfn   [NRD]
);
   localparam bit FULL_DEPTH = (ENTRIES == (2 ** IDX_W));

   logic [ENTRIES-1:0] vld_q;
   logic [PFN_W-1:0]   pfn_q [ENTRIES];
   logic               wr_rng;
   logic [SEL_W-1:0]   wr_sel;

   // Range decode: a full-depth table needs no compare
   if (FULL_DEPTH) begin : g_wr_full
      assign wr_rng = 1'b1;
   end else begin : g_wr_part
      assign wr_rng = (wr_idx < IDX_W'(ENTRIES));
   end
   assign wr_sel = wr_idx[SEL_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else if (wr_en && wr_rng) begin
         vld_q[wr_sel] <= wr_valid;
      end
   end

   // Page frames carry no reset: the valid flag gates every use
   always_ff @(posedge clk) begin
      if (wr_en && wr_rng) begin
         pfn_q[wr_sel] <= wr_pfn;
      end
   end

   for (genvar p = 0; p < NRD; p++) begin : g_rd
      logic             rng;
      logic [SEL_W-1:0] sel;
      if (FULL_DEPTH) begin : g_full
         assign rng = 1'b1;
      end else begin : g_part
         assign rng = (rd_idx[p] < IDX_W'(ENTRIES));
      end
      assign sel         = rd_idx[p][SEL_W-1:0];
      assign rd_valid[p] = rng && vld_q[sel];
      assign rd_pfn[p]   = rng ? pfn_q[sel] : '0;
   end
endmodule

// File: rtl/sgmap_xlate_stage.sv
module sgmap_xlate_stage
   import sgmap_pkg::*;
#(
   parameter int unsigned OFF_W = 9,
   parameter int unsigned PFN_W = 15,
   localparam int unsigned PA_W = PFN_W + OFF_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [OFF_W-1:0] req_off,
   input  logic             lk_hit,
   input  logic [PFN_W-1:0] lk_pfn,
   output logic             rsp_valid,
   input  logic             rsp_ready,
   output logic [PA_W-1:0]  rsp_paddr,
   output logic             rsp_err
);
   logic       vld_q;
   logic [PA_W-1:0] pa_q;
   xl_status_e st_q;
   logic       take;

   assign req_ready = !vld_q || rsp_ready;
   assign take      = req_valid && req_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         pa_q  <= '0;
         st_q  <= XL_OK;
      end else begin
         if (req_ready) begin
            vld_q <= req_valid;
         end
         if (take) begin
            pa_q <= lk_hit ? {lk_pfn, req_off} : '0;
            st_q <= lk_hit ? XL_OK : XL_FAULT;
         end
      end
   end

   assign rsp_valid = vld_q;
   assign rsp_paddr = pa_q;
   assign rsp_err   = (st_q == XL_FAULT);
endmodule

// File: rtl/sgmap_dma_xlate.sv
module sgmap_dma_xlate
   import sgmap_pkg::*;
#(
   parameter int unsigned DEV_AW      = 22,
   parameter int unsigned OFF_W       = 9,
   parameter int unsigned PFN_W       = 15,
   parameter int unsigned MAP_ENTRIES = 1024,
   localparam int unsigned IDX_W      = DEV_AW - OFF_W,
   localparam int unsigned PA_W       = PFN_W + OFF_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 host_we,
   input  logic [IDX_W-1:0]     host_idx,
   input  logic [MAP_REG_W-1:0] host_wdata,
   output logic [MAP_REG_W-1:0] host_rdata,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic [DEV_AW-1:0]    req_addr,
   output logic                 rsp_valid,
   input  logic                 rsp_ready,
   output logic [PA_W-1:0]      rsp_paddr,
   output logic                 rsp_err
);
   // Elaboration-time parameter checks
   if (OFF_W == 0 || DEV_AW <= OFF_W) begin : g_bad_aw
      $error("sgmap_dma_xlate: DEV_AW must exceed OFF_W > 0");
   end
   if (PFN_W == 0 || PFN_W >= MAP_VALID_POS) begin : g_bad_pfn
      $error("sgmap_dma_xlate: PFN_W must fit below the valid flag");
   end
   if (MAP_ENTRIES < 2 || MAP_ENTRIES > (2 ** IDX_W)) begin : g_bad_depth
      $error("sgmap_dma_xlate: MAP_ENTRIES out of range");
   end

   localparam int unsigned RD_HOST = 0;
   localparam int unsigned RD_DMA  = 1;

   logic [IDX_W-1:0] rd_idx   [2];
   logic             rd_valid [2];
   logic [PFN_W-1:0] rd_pfn   [2];
   logic             unused_wbits;

   assign rd_idx[RD_HOST] = host_idx;
   assign rd_idx[RD_DMA]  = req_addr[DEV_AW-1:OFF_W];
   assign unused_wbits    = ^host_wdata[MAP_VALID_POS-1:PFN_W];

   sgmap_table #(
      .IDX_W   (IDX_W),
      .PFN_W   (PFN_W),
      .ENTRIES (MAP_ENTRIES),
      .NRD     (2)
   ) u_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (host_we),
      .wr_idx   (host_idx),
      .wr_valid (host_wdata[MAP_VALID_POS]),
      .wr_pfn   (host_wdata[PFN_W-1:0]),
      .rd_idx   (rd_idx),
      .rd_valid (rd_valid),
      .rd_pfn   (rd_pfn)
   );

   always_comb begin
      host_rdata                  = '0;
      host_rdata[MAP_VALID_POS]   = rd_valid[RD_HOST];
      host_rdata[PFN_W-1:0]       = rd_pfn[RD_HOST];
   end

   sgmap_xlate_stage #(
      .OFF_W (OFF_W),
      .PFN_W (PFN_W)
   ) u_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_ready (req_ready),
      .req_off   (req_addr[OFF_W-1:0]),
      .lk_hit    (rd_valid[RD_DMA]),
      .lk_pfn    (rd_pfn[RD_DMA]),
      .rsp_valid (rsp_valid),
      .rsp_ready (rsp_ready),
      .rsp_paddr (rsp_paddr),
      .rsp_err   (rsp_err)
   );
endmodule

// File: rtl/sgmap_dma_xlate_chk.sv
module sgmap_dma_xlate_chk #(
   parameter int unsigned DEV_AW = 22,
   parameter int unsigned OFF_W  = 9,
   parameter int unsigned PA_W   = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [DEV_AW-1:0] req_addr,
   input logic              rsp_valid,
   input logic              rsp_ready,
   input logic [PA_W-1:0]   rsp_paddr,
   input logic              rsp_err
);
   // R6
   resp_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> rsp_valid);

   // R6
   no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!(req_valid && req_ready) && !(rsp_valid && !rsp_ready)) |=> !rsp_valid);

   // R2
   offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=>
         (rsp_err || rsp_paddr[OFF_W-1:0] == $past(req_addr[OFF_W-1:0])));

   // R3
   fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_err) |-> (rsp_paddr == '0));

   // R7
   stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |-> !req_ready);

   // R7
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=>
         (rsp_valid && $stable(rsp_paddr) && $stable(rsp_err)));
endmodule

bind sgmap_dma_xlate sgmap_dma_xlate_chk #(
   .DEV_AW (DEV_AW),
   .OFF_W  (OFF_W),
   .PA_W   (PA_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .req_addr  (req_addr),
   .rsp_valid (rsp_valid),
   .rsp_ready (rsp_ready),
   .rsp_paddr (rsp_paddr),
   .rsp_err   (rsp_err)
);

// File: tb/sgmap_dma_xlate_bench.sv
module sgmap_dma_xlate_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_we = 1'b0;
   logic [12:0] host_idx = '0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [21:0] req_addr = '0;
   logic        rsp_valid;
   logic        rsp_ready = 1'b1;
   logic [23:0] rsp_paddr;
   logic        rsp_err;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   sgmap_dma_xlate u_sgmap_dma_xlate (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_idx(host_idx),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .req_valid(req_valid),
      .req_ready(req_ready), .req_addr(req_addr), .rsp_valid(rsp_valid),
      .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_err(rsp_err)
   );

   typedef struct packed {
      logic [12:0] idx;
      logic [31:0] wdata;
      logic [8:0]  off;
      logic [31:0] exp_rd;
      logic [23:0] exp_pa;
      logic        exp_err;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VEC [NV] = '{
      '{13'd0,    32'h8000_0001, 9'h000, 32'h8000_0001, 24'h000200, 1'b0},
      '{13'd1,    32'h8000_7FFF, 9'h1FF, 32'h8000_7FFF, 24'hFFFFFF, 1'b0},
      '{13'd5,    32'h0000_1234, 9'h0AB, 32'h0000_1234, 24'h000000, 1'b1},
      '{13'd1023, 32'h8000_4321, 9'h100, 32'h8000_4321, 24'h864300, 1'b0},
      '{13'd300,  32'hFFFF_FFFF, 9'h055, 32'h8000_7FFF, 24'hFFFE55, 1'b0},
      '{13'd1024, 32'h8000_0ABC, 9'h010, 32'h0000_0000, 24'h000000, 1'b1},
      '{13'd8191, 32'h8000_0002, 9'h001, 32'h0000_0000, 24'h000000, 1'b1},
      '{13'd2,    32'h8000_0000, 9'h1C0, 32'h8000_0000, 24'h0001C0, 1'b0}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic host_write(input logic [12:0] idx, input logic [31:0] d);
      @(negedge clk);
      host_we = 1'b1; host_idx = idx; host_wdata = d;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic host_read(input logic [12:0] idx, output logic [31:0] d);
      @(negedge clk);
      host_idx = idx;
      #1 d = host_rdata;
   endtask

   // One request with rsp_ready high; result sampled right after the accepting edge
   task automatic xlate(input logic [21:0] a, output logic [23:0] pa, output logic er);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a;
      #1 chk("R6 idle before accept", {31'd0, rsp_valid}, 32'd0);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R6 valid one cycle after accept", {31'd0, rsp_valid}, 32'd1);
      pa = rsp_paddr; er = rsp_err;
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      logic [31:0] rd;
      logic [23:0] pa;
      logic        er;

      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R5 / R6: reset state
      chk("R6 req_ready after reset", {31'd0, req_ready}, 32'd1);
      chk("R6 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
      host_read(13'd0, rd);
      chk("R5 valid flag cleared", {31'd0, rd[31]}, 32'd0);
      xlate({13'd0, 9'h010}, pa, er);
      chk("R5 fault before load", {31'd0, er}, 32'd1);
      chk("R5 zero address before load", {8'd0, pa}, 32'd0);

      // R1 R2 R3 R4 R9: vector table
      for (int i = 0; i < NV; i++) begin
         host_write(VEC[i].idx, VEC[i].wdata);
         host_read(VEC[i].idx, rd);
         chk("R4 R9 readback", rd, VEC[i].exp_rd);
         xlate({VEC[i].idx, VEC[i].off}, pa, er);
         chk("R1 R3 R9 error flag", {31'd0, er}, {31'd0, VEC[i].exp_err});
         chk("R1 R2 R3 physical address", {8'd0, pa}, {8'd0, VEC[i].exp_pa});
      end

      // R9: write to index 1024 must not alias entry 0
      host_read(13'd0, rd);
      chk("R9 no alias into entry 0", rd, 32'h8000_0001);

      // R8: same-edge write and lookup on entry 7
      host_write(13'd7, 32'h8000_0111);
      @(negedge clk);
      host_we = 1'b1; host_idx = 13'd7; host_wdata = 32'h8000_0222;
      req_valid = 1'b1; req_addr = {13'd7, 9'h000};
      @(negedge clk);
      host_we = 1'b0; req_valid = 1'b0;
      chk("R8 lookup sees old frame", {8'd0, rsp_paddr}, 32'h0002_2200);
      xlate({13'd7, 9'h000}, pa, er);
      chk("R8 next lookup sees new frame", {8'd0, pa}, 32'h0004_4400);

      // R7: back-pressure
      @(negedge clk);
      rsp_ready = 1'b0;
      req_valid = 1'b1; req_addr = {13'd0, 9'h003};
      @(negedge clk);
      req_addr = {13'd1, 9'h004};
      chk("R7 first response", {8'd0, rsp_paddr}, 32'h0000_0203);
      chk("R7 ready low during stall", {31'd0, req_ready}, 32'd0);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk("R7 response held", {8'd0, rsp_paddr}, 32'h0000_0203);
         chk("R7 valid held", {31'd0, rsp_valid}, 32'd1);
      end
      rsp_ready = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R7 waiting request answered", {8'd0, rsp_paddr}, 32'h00FF_FE04);
      chk("R7 waiting request valid", {31'd0, rsp_valid}, 32'd1);
      @(negedge clk);
      chk("R6 drained", {31'd0, rsp_valid}, 32'd0);

      // R5: reset in the middle of operation
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      host_read(13'd1, rd);
      chk("R5 valid cleared by second reset", {31'd0, rd[31]}, 32'd0);
      xlate({13'd1, 9'h004}, pa, er);
      chk("R5 fault after second reset", {31'd0, er}, 32'd1);

      summary();
   end
endmodule